// File: doc/BRIEF.md
# SDRAM Bank Window Configuration Word Codec

This block converts between a physical view of a memory bank, meaning a base address and a size, and the packed 32-bit configuration word that a memory controller keeps for each bank. It is purely combinational and has three independent paths. The encoder packs a base and a size into a word, or flags the size as unsupported. The decoder unpacks any word into a base and a size. The window checker tells whether a physical address falls inside the bank that the decoded word describes.

The size is held as a 10-bit field in word bits 15:6. The number of 8 MiB units is 1024 minus the field value. The base is stored pre-shifted right by two, so the 11 bits at word positions 31:21 span a 34-bit physical address with 8 MiB granularity. Bit 0 enables the bank. A controller instantiates one codec per bank, or shares one across banks, and wraps its own register access and arbitration around it.

Top module: `bankcfg_codec`

## Requirements
- R1: For a supported size of 2^(23+k) bytes, k from 0 to 9, the encoder puts 1024 − 2^k into word bits 15:6. For example, 8 MiB gives bits 15:0 = 0xFFC0 before the enable bit, 256 MiB gives 0xF800 and 4 GiB gives 0x8000.
- R2: For a supported size, the encoder sets word bit 0 (enable) to 1.
- R3: For a supported size, word bits 31:21 equal base bits 33:23, and word bits 20:16 and 5:1 are 0. Base bits 22:0 have no effect.
- R4: A size that is not a power of two in the range 8 MiB to 4 GiB, including zero, gives `enc_invalid` = 1 and an all-zero word. A supported size gives `enc_invalid` = 0.
- R5: The decoded base equals word bits 31:21 placed at address bits 33:23, with address bits 22:0 equal to 0.
- R6: The decoded size equals 8 MiB × (1024 − word[15:6]), so a field of 0 decodes to 8 GiB. Word bits 20:16 and 5:1 have no effect on the base or the size.
- R7: `hit` is 1 exactly when word bit 0 is 1 and base ≤ `hit_addr` < base + size.
- R8: The upper window bound is computed one bit wider than the address, so a window that reaches past the top of the 34-bit space still hits every address from its base up to the top address.
- R9: Decoding an encoded word returns the input base with bits 22:0 cleared and exactly the input size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_base | input | 34 | Bank base physical address to encode |
| enc_size | input | 34 | Bank size in bytes to encode |
| enc_word | output | 32 | Encoded configuration word |
| enc_invalid | output | 1 | Size not supported; word forced to zero |
| dec_word | input | 32 | Configuration word to decode |
| dec_base | output | 34 | Decoded base physical address |
| dec_size | output | 34 | Decoded size in bytes |
| hit_addr | input | 34 | Physical address to test against the decoded window |
| hit | output | 1 | Address lies inside the enabled window |

## Verification
The encoder is tried with every single-bit size from 2^0 to 2^33. This separates the ten supported sizes from the too-small and too-large powers of two. Sizes with extra bits set, and zero, catch a check that tests only the range or only the bit count. Both encoder variants are driven side by side with bases chosen to toggle both the kept and the discarded address bits. The decoder is swept through all 1024 field codes, with ones in the unused word bits, so any leakage of those bits shows up. The window checker is probed just below, at, at the last byte of and just past each window, with the enable bit set and cleared, and with a window that runs off the top of the address space.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
   // Encoder implementation variants
   typedef enum logic [0:0] {
      ENC_ARITH = 1'b0,   // power-of-two test plus subtraction
      ENC_SCAN  = 1'b1    // compare against each legal size
   } enc_style_e;

   localparam int DEF_PADDR_W   = 34;
   localparam int DEF_WORD_W    = 32;
   localparam int DEF_UNIT_LOG2 = 23;  // 8 MiB granule
   localparam int DEF_MAX_LOG2  = 32;  // 4 GiB largest encodable
   localparam int DEF_FIELD_LSB = 6;
   localparam int DEF_FIELD_W   = 10;
   localparam int DEF_BASE_LSB  = 21;
endpackage

// File: rtl/bcw_encoder.sv
module bcw_encoder
   import bcw_pkg::*;
#(
   parameter int         PADDR_W   = DEF_PADDR_W,
   parameter int         WORD_W    = DEF_WORD_W,
   parameter int         UNIT_LOG2 = DEF_UNIT_LOG2,
   parameter int         MAX_LOG2  = DEF_MAX_LOG2,
   parameter int         FIELD_LSB = DEF_FIELD_LSB,
   parameter int         FIELD_W   = DEF_FIELD_W,
   parameter int         BASE_LSB  = DEF_BASE_LSB,
   parameter enc_style_e STYLE     = ENC_ARITH
) (
   input  logic [PADDR_W-1:0] base_i,
   input  logic [PADDR_W-1:0] size_i,
   output logic [WORD_W-1:0]  word_o,
   output logic               invalid_o
);
   localparam int BASE_SRC_LO = BASE_LSB + (PADDR_W - WORD_W);
   localparam int NUM_SIZES   = MAX_LOG2 - UNIT_LOG2 + 1;
   localparam int FIELD_SPAN  = 1 << FIELD_W;
   localparam logic [PADDR_W-1:0] MIN_SIZE = PADDR_W'(1) << UNIT_LOG2;
   localparam logic [PADDR_W-1:0] MAX_SIZE = PADDR_W'(1) << MAX_LOG2;

   logic               ok;
   logic [FIELD_W-1:0] field;
   logic               unused_base_lo;
   assign unused_base_lo = ^base_i[BASE_SRC_LO-1:0];

   generate
      if (STYLE == ENC_ARITH) begin : g_arith
         logic [PADDR_W-1:0] units;
         logic [PADDR_W:0]   diff;
         always_comb begin
            units = size_i >> UNIT_LOG2;
            diff  = (PADDR_W+1)'(FIELD_SPAN) - {1'b0, units};
            ok    = ($countones(size_i) == 1) && (size_i >= MIN_SIZE)
                    && (size_i <= MAX_SIZE);
            field = diff[FIELD_W-1:0];
         end
      end else begin : g_scan
         always_comb begin
            ok    = 1'b0;
            field = '0;
            for (int k = 0; k < NUM_SIZES; k++) begin
               if (size_i == (MIN_SIZE << k)) begin
                  ok    = 1'b1;
                  field = FIELD_W'(FIELD_SPAN - (1 << k));
               end
            end
         end
      end
   endgenerate

   always_comb begin
      word_o = '0;
      if (ok) begin
         word_o[WORD_W-1:BASE_LSB]     = base_i[PADDR_W-1:BASE_SRC_LO];
         word_o[FIELD_LSB +: FIELD_W]  = field;
         word_o[0]                     = 1'b1;
      end
      invalid_o = !ok;
   end

   // Assertions beside the packing logic
   logic [PADDR_W:0] back_size;
   always_comb begin
      back_size = ((PADDR_W+1)'(FIELD_SPAN)
                   - (PADDR_W+1)'(word_o[FIELD_LSB +: FIELD_W])) << UNIT_LOG2;
      if (invalid_o) begin
         a_r4_invalid_word_zero: assert (word_o == '0)
            else $error("R4: rejected size left a nonzero word");
      end else begin
         a_r2_enable_set: assert (word_o[0])
            else $error("R2: accepted size without enable bit");
         a_r9_size_roundtrip: assert (back_size == {1'b0, size_i})
            else $error("R9: size field does not reproduce input size");
      end
   end
endmodule

// File: rtl/bcw_decoder.sv
module bcw_decoder
   import bcw_pkg::*;
#(
   parameter int PADDR_W   = DEF_PADDR_W,
   parameter int WORD_W    = DEF_WORD_W,
   parameter int UNIT_LOG2 = DEF_UNIT_LOG2,
   parameter int FIELD_LSB = DEF_FIELD_LSB,
   parameter int FIELD_W   = DEF_FIELD_W,
   parameter int BASE_LSB  = DEF_BASE_LSB
) (
   input  logic [WORD_W-1:0]  word_i,
   output logic [PADDR_W-1:0] base_o,
   output logic [PADDR_W-1:0] size_o,
   output logic               en_o
);
   localparam int BASE_SRC_LO = BASE_LSB + (PADDR_W - WORD_W);
   localparam int FIELD_SPAN  = 1 << FIELD_W;

   logic [FIELD_W:0] units;
   logic             unused_gap;
   assign unused_gap = ^{word_i[BASE_LSB-1:FIELD_LSB+FIELD_W],
                         word_i[FIELD_LSB-1:1]};

   always_comb begin
      base_o = '0;
      base_o[PADDR_W-1:BASE_SRC_LO] = word_i[WORD_W-1:BASE_LSB];
      units  = (FIELD_W+1)'(FIELD_SPAN) - {1'b0, word_i[FIELD_LSB +: FIELD_W]};
      size_o = PADDR_W'(units) << UNIT_LOG2;
      en_o   = word_i[0];
   end

   always_comb begin
      a_r6_size_granule: assert ((size_o != '0) && (size_o[UNIT_LOG2-1:0] == '0))
         else $error("R6: decoded size is zero or off granule");
      a_r5_base_granule: assert (base_o[BASE_SRC_LO-1:0] == '0)
         else $error("R5: decoded base has low bits set");
   end
endmodule

// File: rtl/bcw_window.sv
module bcw_window
   import bcw_pkg::*;
#(
   parameter int PADDR_W = DEF_PADDR_W
) (
   input  logic [PADDR_W-1:0] base_i,
   input  logic [PADDR_W-1:0] size_i,
   input  logic               en_i,
   input  logic [PADDR_W-1:0] addr_i,
   output logic               hit_o
);
   // One extra bit keeps base+size from wrapping at the top of the space
   logic [PADDR_W:0] limit;
   always_comb begin
      limit = {1'b0, base_i} + {1'b0, size_i};
      hit_o = en_i && (addr_i >= base_i) && ({1'b0, addr_i} < limit);
   end

   always_comb begin
      if (!en_i) begin
         a_r7_disabled_no_hit: assert (!hit_o)
            else $error("R7: disabled window reported a hit");
      end
   end
endmodule

// File: rtl/bankcfg_codec.sv
module bankcfg_codec
   import bcw_pkg::*;
#(
   parameter int         PADDR_W   = DEF_PADDR_W,
   parameter int         WORD_W    = DEF_WORD_W,
   parameter int         UNIT_LOG2 = DEF_UNIT_LOG2,
   parameter int         MAX_LOG2  = DEF_MAX_LOG2,
   parameter int         FIELD_LSB = DEF_FIELD_LSB,
   parameter int         FIELD_W   = DEF_FIELD_W,
   parameter int         BASE_LSB  = DEF_BASE_LSB,
   parameter enc_style_e ENC_STYLE = ENC_ARITH
) (
   input  logic [PADDR_W-1:0] enc_base,
   input  logic [PADDR_W-1:0] enc_size,
   output logic [WORD_W-1:0]  enc_word,
   output logic               enc_invalid,
   input  logic [WORD_W-1:0]  dec_word,
   output logic [PADDR_W-1:0] dec_base,
   output logic [PADDR_W-1:0] dec_size,
   input  logic [PADDR_W-1:0] hit_addr,
   output logic               hit
);
   localparam int BASE_SRC_LO = BASE_LSB + (PADDR_W - WORD_W);
   localparam int LARGEST_UNITS = 1 << (MAX_LOG2 - UNIT_LOG2);

   // Elaboration-time parameter checks
   generate
      if (FIELD_LSB < 2) begin : g_bad_field_lsb
         $error("field must leave bits between itself and the enable bit");
      end
      if (FIELD_LSB + FIELD_W >= BASE_LSB) begin : g_bad_overlap
         $error("size field overlaps or abuts the base field");
      end
      if (BASE_LSB >= WORD_W || PADDR_W <= WORD_W) begin : g_bad_base
         $error("base field placement does not fit word and address widths");
      end
      if (BASE_SRC_LO != UNIT_LOG2) begin : g_bad_granule
         $error("base granule and size granule differ");
      end
      if (LARGEST_UNITS > (1 << (FIELD_W - 1))) begin : g_bad_range
         $error("largest size does not fit the size field");
      end
      if (PADDR_W < FIELD_W + 1 + UNIT_LOG2) begin : g_bad_size_w
         $error("size output too narrow for the field span");
      end
   endgenerate

   logic dec_en;

   bcw_encoder #(
      .PADDR_W(PADDR_W), .WORD_W(WORD_W), .UNIT_LOG2(UNIT_LOG2),
      .MAX_LOG2(MAX_LOG2), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
      .BASE_LSB(BASE_LSB), .STYLE(ENC_STYLE)
   ) u_enc (
      .base_i(enc_base), .size_i(enc_size),
      .word_o(enc_word), .invalid_o(enc_invalid)
   );

   bcw_decoder #(
      .PADDR_W(PADDR_W), .WORD_W(WORD_W), .UNIT_LOG2(UNIT_LOG2),
      .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .BASE_LSB(BASE_LSB)
   ) u_dec (
      .word_i(dec_word), .base_o(dec_base), .size_o(dec_size), .en_o(dec_en)
   );

   bcw_window #(
      .PADDR_W(PADDR_W)
   ) u_win (
      .base_i(dec_base), .size_i(dec_size), .en_i(dec_en),
      .addr_i(hit_addr), .hit_o(hit)
   );

   always_comb begin
      if (hit) begin
         a_r8_hit_inside_span: assert (dec_word[0] && (hit_addr >= dec_base)
                                       && ((hit_addr - dec_base) < dec_size))
            else $error("R8: hit outside the decoded window");
      end
   end
endmodule

// File: tb/bankcfg_codec_tb.sv
module bankcfg_codec_tb;
   import bcw_pkg::*;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [33:0] enc_base, enc_size, dec_base, dec_size, hit_addr;
   logic [33:0] dec_base_s, dec_size_s;
   logic [31:0] enc_word, dec_word, enc_word_s;
   logic        enc_invalid, enc_invalid_s, hit, hit_s;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bankcfg_codec u_dut (
      .enc_base(enc_base), .enc_size(enc_size), .enc_word(enc_word),
      .enc_invalid(enc_invalid), .dec_word(dec_word), .dec_base(dec_base),
      .dec_size(dec_size), .hit_addr(hit_addr), .hit(hit)
   );

   bankcfg_codec #(.ENC_STYLE(ENC_SCAN)) u_dut_scan (
      .enc_base(enc_base), .enc_size(enc_size), .enc_word(enc_word_s),
      .enc_invalid(enc_invalid_s), .dec_word(dec_word), .dec_base(dec_base_s),
      .dec_size(dec_size_s), .hit_addr(hit_addr), .hit(hit_s)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic bit size_ok(longint s);
      return (s >= (64'd1 << 23)) && (s <= (64'd1 << 32)) && ((s & (s - 1)) == 0);
   endfunction

   function automatic longint exp_word(longint b, longint s);
      if (!size_ok(s)) return 0;
      return ((b >> 2) & 64'hFFE0_0000) | ((1024 - (s >> 23)) << 6) | 1;
   endfunction

   task automatic check_encode(longint b, longint s);
      longint ew;
      @(negedge clk);
      enc_base = 34'(b);
      enc_size = 34'(s);
      settle();
      ew = exp_word(b, s);
      chk("R4 invalid flag", enc_invalid, size_ok(s) ? 0 : 1);
      chk("R4 invalid flag scan", enc_invalid_s, size_ok(s) ? 0 : 1);
      chk("R1 size field", (enc_word >> 6) & 1023, (ew >> 6) & 1023);
      chk("R2 enable bit", enc_word & 1, ew & 1);
      chk("R3 base and gap bits", enc_word & 32'hFFFF_003E, ew & 64'hFFFF_003E);
      chk("R1 scan variant word", enc_word_s, ew);
      if (size_ok(s)) begin
         dec_word = enc_word;
         settle();
         chk("R9 roundtrip base", dec_base, b & 64'h3_FF80_0000);
         chk("R9 roundtrip size", dec_size, s);
      end
   endtask

   task automatic check_hit(logic [31:0] w, longint a);
      longint b, s, lim;
      bit e;
      b   = (longint'(w) & 64'hFFE0_0000) << 2;
      s   = (1024 - ((longint'(w) >> 6) & 1023)) << 23;
      lim = b + s;
      e   = w[0] && (a >= b) && (a < lim) && (a >= 0) && (a <= 64'h3_FFFF_FFFF);
      @(negedge clk);
      dec_word = w;
      hit_addr = 34'(a);
      settle();
      chk("R7 window hit", hit, e);
      chk("R7 window hit scan", hit_s, e);
   endtask

   initial begin
      longint bases [6] = '{64'h0, 64'h3_FFFF_FFFF, 64'h1_2345_6789,
                            64'h2_AAAA_5555, 64'h0_0080_0000, 64'h0_007F_FFFF};
      longint bad [8]   = '{64'h0, 64'h40_0000, 64'h2_0000_0000, 64'h80_0001,
                            64'h180_0000, 64'h1_0080_0000, 64'h3_FFFF_FFFF,
                            64'h10_0000};
      logic [31:0] wins [6] = '{32'h0000_FFC1, 32'h4560_E001, 32'h8001_F801,
                                32'hFFE0_FFC1, 32'h2000_0001, 32'hFFE0_8001};
      enc_base = '0; enc_size = '0; dec_word = '0; hit_addr = '0;
      settle();
      // Idle state: zero size rejected, word zero decodes to 8 GiB at 0
      chk("R4 zero size rejected", enc_invalid, 1);
      chk("R4 zero size word", enc_word, 0);
      chk("R6 zero field 8 GiB", dec_size, 64'h2_0000_0000);
      chk("R7 disabled no hit", hit, 0);

      // Every legal size with varied bases (R1, R2, R3, R9)
      for (int k = 0; k < 10; k++)
         foreach (bases[i]) check_encode(bases[i], 64'd1 << (23 + k));
      // Single-bit sizes over the whole input width (R4)
      for (int j = 0; j < 34; j++) check_encode(64'h1_5555_AAAA, 64'd1 << j);
      foreach (bad[i]) check_encode(64'h3_FFFF_FFFF, bad[i]);

      // Every field code, gap bits set (R5, R6)
      for (int f = 0; f < 1024; f++) begin
         logic [31:0] w;
         w = {11'((f * 37) & 11'h7FF), 5'h1F, 10'(f), 5'h1F, 1'b0};
         @(negedge clk);
         dec_word = w;
         settle();
         chk("R5 decoded base", dec_base, (longint'(w) & 64'hFFE0_0000) << 2);
         chk("R6 decoded size", dec_size, longint'(1024 - f) << 23);
         chk("R6 decoded size scan", dec_size_s, longint'(1024 - f) << 23);
      end

      // Window edges, enabled and disabled (R7)
      foreach (wins[i]) begin
         longint b, s;
         b = (longint'(wins[i]) & 64'hFFE0_0000) << 2;
         s = (1024 - ((longint'(wins[i]) >> 6) & 1023)) << 23;
         for (int en = 0; en < 2; en++) begin
            logic [31:0] w;
            w = {wins[i][31:1], 1'(en)};
            check_hit(w, b - 1);
            check_hit(w, b);
            check_hit(w, b + s - 1);
            check_hit(w, b + s);
            check_hit(w, 0);
            check_hit(w, 64'h3_FFFF_FFFF);
         end
      end

      // Window running off the top of the address space (R8)
      @(negedge clk);
      dec_word = 32'hFFE0_8001;
      hit_addr = 34'h3_FFFF_FFFF;
      settle();
      chk("R8 top address inside wrapped window", hit, 1);
      @(negedge clk);
      hit_addr = 34'h3_FF80_0000;
      settle();
      chk("R8 base of top window", hit, 1);
      @(negedge clk);
      hit_addr = 34'h3_FF7F_FFFF;
      settle();
      chk("R8 below top window", hit, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule